// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small programmable logic device. The product terms arrive from the AND array already evaluated. The cell gathers its own native terms and any borrowed terms from neighbouring cells that the mask enables, and ORs them into a sum. It inverts the sum if a polarity bit is set. The result goes either straight to the pin through a combinational bypass, or through a storage element. The storage element acts as a D, T, JK or SR flip-flop, as a static mode field selects.

A per-term group mask gives each native term to one of two groups. Terms in the set group feed the main sum. Terms in the reset group form the second excitation input that the JK and SR modes need.

The register advances only on a rising edge of its selected clock source. That source is either a product term or a dedicated external clock input, and both are sampled against the system clock. Preset and clear are active high and act on the output at once. The clear is formed from up to two enabled product terms, and it wins over the preset. A processor-side data bit can write the register with a load strobe, and it can read the register back at any time.

The same output drives the pin-side port and the feedback path into the array.

Top module: `pld_out_cell`

## Requirements
- R1: With `cfg_out_reg`=0, `pin_out` equals the sum XOR `cfg_inv`. The sum is the OR of each native term whose `cfg_rgrp` bit is 0 and each borrowed term whose `cfg_brw_en` bit is 1. A borrowed term whose enable bit is 0 has no effect on the output.
- R2: With `cfg_inv`=1, the combinational output is the inverse of the OR sum.
- R3: `fb_out` always carries the same value as `pin_out`.
- R4: In mode 0 (D), a clock event loads the polarity-adjusted sum into the register. With `cfg_out_reg`=1, the register value is visible on `pin_out` and `cpu_q` from the following cycle.
- R5: In mode 1 (T), a clock event inverts the register when the polarity-adjusted sum is 1, and keeps it when the sum is 0.
- R6: In mode 2 (JK), J is the polarity-adjusted sum and K is the OR of the reset-group native terms (`cfg_rgrp` bit 1). On a clock event: 00 holds, 10 sets, 01 clears and 11 toggles.
- R7: In mode 3 (SR), S and R are formed in the same way as J and K in R6. On a clock event: 10 sets and 01 clears, while 00 and 11 both hold.
- R8: A clock event is a 0-to-1 change, seen on a `clk` edge, of the selected source. The source is `pt_clk` when `cfg_clk_pt`=1 and `clk_in` otherwise. A source that stays high, or the unselected source, never updates the register.
- R9: If any clear term is high together with its `cfg_clr_en` bit, `cpu_q` and the registered output read 0 in the same cycle, and the register stays 0. Clear wins over preset.
- R10: If `pt_pre` and `cfg_pre_en` are both high and no clear is active, `cpu_q` reads 1 in the same cycle, and the register stays 1.
- R11: `cpu_ld`=1 at a `clk` edge writes `cpu_d` into the register. It overrides any clock event in the same cycle. `cpu_q` always returns the register contents.
- R12: While `rst_n` is low, the register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the clock sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_nat | input | N_NAT | Native product terms |
| cfg_rgrp | input | N_NAT | 1 puts a native term in the reset group |
| pt_brw | input | N_BRW | Borrowed product terms from neighbours |
| cfg_brw_en | input | N_BRW | Enable mask for borrowed terms |
| cfg_inv | input | 1 | Polarity inversion of the sum |
| cfg_mode | input | 2 | Register type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_pt | input | 1 | 1 selects the product-term clock |
| cfg_out_reg | input | 1 | 1 selects the registered output path |
| clk_in | input | 1 | Dedicated external clock input |
| pt_clk | input | 1 | Product-term clock |
| pt_pre | input | 1 | Preset product term |
| cfg_pre_en | input | 1 | Preset enable |
| pt_clr | input | N_CLR | Clear product terms |
| cfg_clr_en | input | N_CLR | Clear term enables |
| cpu_ld | input | 1 | Processor load strobe |
| cpu_d | input | 1 | Processor data bit for loading |
| cpu_q | output | 1 | Processor read-back of the register |
| pin_out | output | 1 | Pin-side output |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The bench builds the cell with four native terms, six borrowed terms and two clear terms. This is the wider cell group, so the full borrow mask and both clear terms can be checked. Four native terms are enough for random group masks to produce every JK and SR input pair, including both-high. Random mixes of clock-source levels, forcing terms and load strobes reach the priority order between clear, preset, load and clock events. Directed cases cover a source held high, toggling of the unselected source, and clear against preset.

// File: rtl/pld_oc_pkg.sv
package pld_oc_pkg;
   typedef enum logic [1:0] {
      FFM_D  = 2'd0,
      FFM_T  = 2'd1,
      FFM_JK = 2'd2,
      FFM_SR = 2'd3
   } ff_mode_e;
endpackage

// File: rtl/pld_oc_sum.sv
module pld_oc_sum #(
   parameter int N_NAT = 4,
   parameter int N_BRW = 6
) (
   input  logic [N_NAT-1:0] pt_nat,
   input  logic [N_NAT-1:0] rgrp,
   input  logic [N_BRW-1:0] pt_brw,
   input  logic [N_BRW-1:0] brw_en,
   input  logic             inv,
   output logic             set_t,
   output logic             rst_t
);
   logic [N_NAT-1:0] set_v;
   logic [N_NAT-1:0] rst_v;
   logic [N_BRW-1:0] brw_v;

   for (genvar i = 0; i < N_NAT; i++) begin : g_nat
      assign set_v[i] = pt_nat[i] & ~rgrp[i];
      assign rst_v[i] = pt_nat[i] &  rgrp[i];
   end

   for (genvar j = 0; j < N_BRW; j++) begin : g_brw
      assign brw_v[j] = pt_brw[j] & brw_en[j];
   end

   assign set_t = ((|set_v) | (|brw_v)) ^ inv;
   assign rst_t = |rst_v;
endmodule

// File: rtl/pld_oc_clk.sv
module pld_oc_clk (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_in,
   input  logic pt_clk,
   input  logic sel_pt,
   output logic fire
);
   logic prev_ext;
   logic prev_pt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ext <= 1'b0;
         prev_pt  <= 1'b0;
      end else begin
         prev_ext <= clk_in;
         prev_pt  <= pt_clk;
      end
   end

   assign fire = sel_pt ? (pt_clk & ~prev_pt) : (clk_in & ~prev_ext);
endmodule

// File: rtl/pld_oc_ff.sv
module pld_oc_ff
   import pld_oc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       s,
   input  logic       r,
   input  logic       fire,
   input  logic       ld,
   input  logic       ld_d,
   input  logic       clr,
   input  logic       pre,
   output logic       q_eff
);
   logic     q;
   logic     q_nxt;
   ff_mode_e m;

   assign m = ff_mode_e'(mode);

   always_comb begin
      unique case (m)
         FFM_D:  q_nxt = s;
         FFM_T:  q_nxt = q ^ s;
         FFM_JK: q_nxt = (s & ~q) | (~r & q);
         FFM_SR: q_nxt = (s ^ r) ? s : q;
         default: q_nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (clr)  q <= 1'b0;
      else if (pre)  q <= 1'b1;
      else if (ld)   q <= ld_d;
      else if (fire) q <= q_nxt;
   end

   assign q_eff = clr ? 1'b0 : (pre ? 1'b1 : q);
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
   parameter int N_NAT = 4,
   parameter int N_BRW = 6,
   parameter int N_CLR = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_NAT-1:0] pt_nat,
   input  logic [N_NAT-1:0] cfg_rgrp,
   input  logic [N_BRW-1:0] pt_brw,
   input  logic [N_BRW-1:0] cfg_brw_en,
   input  logic             cfg_inv,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_clk_pt,
   input  logic             cfg_out_reg,
   input  logic             clk_in,
   input  logic             pt_clk,
   input  logic             pt_pre,
   input  logic             cfg_pre_en,
   input  logic [N_CLR-1:0] pt_clr,
   input  logic [N_CLR-1:0] cfg_clr_en,
   input  logic             cpu_ld,
   input  logic             cpu_d,
   output logic             cpu_q,
   output logic             pin_out,
   output logic             fb_out
);
   localparam int TOTAL_TERMS = N_NAT + N_BRW;

   if (N_NAT < 2) begin : g_bad_nat
      $error("pld_out_cell: N_NAT must be at least 2");
   end
   if (N_BRW < 1 || TOTAL_TERMS > 16) begin : g_bad_brw
      $error("pld_out_cell: N_BRW out of range");
   end
   if (N_CLR < 1 || N_CLR > 2) begin : g_bad_clr
      $error("pld_out_cell: N_CLR must be 1 or 2");
   end

   logic set_t;
   logic rst_t;
   logic fire;
   logic clr_any;
   logic pre_any;
   logic q_eff;
   logic comb_out;
   logic sel_out;

   pld_oc_sum #(.N_NAT(N_NAT), .N_BRW(N_BRW)) u_sum (
      .pt_nat (pt_nat),
      .rgrp   (cfg_rgrp),
      .pt_brw (pt_brw),
      .brw_en (cfg_brw_en),
      .inv    (cfg_inv),
      .set_t  (set_t),
      .rst_t  (rst_t)
   );

   pld_oc_clk u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clk_in (clk_in),
      .pt_clk (pt_clk),
      .sel_pt (cfg_clk_pt),
      .fire   (fire)
   );

   if (N_CLR == 1) begin : g_clr1
      assign clr_any = pt_clr[0] & cfg_clr_en[0];
   end else begin : g_clr2
      assign clr_any = (pt_clr[0] & cfg_clr_en[0]) | (pt_clr[1] & cfg_clr_en[1]);
   end

   assign pre_any = pt_pre & cfg_pre_en;

   pld_oc_ff u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (cfg_mode),
      .s     (set_t),
      .r     (rst_t),
      .fire  (fire),
      .ld    (cpu_ld),
      .ld_d  (cpu_d),
      .clr   (clr_any),
      .pre   (pre_any),
      .q_eff (q_eff)
   );

   assign comb_out = set_t;
   assign sel_out  = cfg_out_reg ? q_eff : comb_out;
   assign pin_out  = sel_out;
   assign fb_out   = sel_out;
   assign cpu_q    = q_eff;
endmodule

// File: rtl/pld_oc_chk.sv
module pld_oc_chk #(
   parameter int N_NAT = 4,
   parameter int N_BRW = 6,
   parameter int N_CLR = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_NAT-1:0] pt_nat,
   input logic [N_NAT-1:0] cfg_rgrp,
   input logic [N_BRW-1:0] pt_brw,
   input logic [N_BRW-1:0] cfg_brw_en,
   input logic             cfg_inv,
   input logic [1:0]       cfg_mode,
   input logic             cfg_clk_pt,
   input logic             cfg_out_reg,
   input logic             clk_in,
   input logic             pt_clk,
   input logic             pt_pre,
   input logic             cfg_pre_en,
   input logic [N_CLR-1:0] pt_clr,
   input logic [N_CLR-1:0] cfg_clr_en,
   input logic             cpu_ld,
   input logic             cpu_d,
   input logic             cpu_q,
   input logic             pin_out
);
   logic p_ext, p_pt, ev, s_c, clr_c, pre_c, frc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_ext <= 1'b0;
         p_pt  <= 1'b0;
      end else begin
         p_ext <= clk_in;
         p_pt  <= pt_clk;
      end
   end

   assign ev    = cfg_clk_pt ? (pt_clk && !p_pt) : (clk_in && !p_ext);
   assign s_c   = ((|(pt_nat & ~cfg_rgrp)) || (|(pt_brw & cfg_brw_en))) ^ cfg_inv;
   assign clr_c = |(pt_clr & cfg_clr_en);
   assign pre_c = pt_pre && cfg_pre_en;
   assign frc   = clr_c || pre_c;

   // R1
   comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_out_reg |-> pin_out == s_c);

   // R4
   d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && ev && !cpu_ld && !frc) |=> (frc || cpu_q == $past(s_c)));

   // R8
   no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev && !cpu_ld && !frc) |=> (frc || $stable(cpu_q)));

   // R9
   clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c |-> !cpu_q);

   // R10
   preset_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_c && !clr_c) |-> cpu_q);

   // R11
   cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ld && !frc) |=> (frc || cpu_q == $past(cpu_d)));

   // R12
   always @(posedge clk) begin
      if (!rst_n && !frc) begin
         reset_clear_chk: assert (cpu_q == 1'b0);
      end
   end
endmodule

bind pld_out_cell pld_oc_chk #(.N_NAT(N_NAT), .N_BRW(N_BRW), .N_CLR(N_CLR)) u_chk (
   .clk(clk), .rst_n(rst_n), .pt_nat(pt_nat), .cfg_rgrp(cfg_rgrp),
   .pt_brw(pt_brw), .cfg_brw_en(cfg_brw_en), .cfg_inv(cfg_inv),
   .cfg_mode(cfg_mode), .cfg_clk_pt(cfg_clk_pt), .cfg_out_reg(cfg_out_reg),
   .clk_in(clk_in), .pt_clk(pt_clk), .pt_pre(pt_pre), .cfg_pre_en(cfg_pre_en),
   .pt_clr(pt_clr), .cfg_clr_en(cfg_clr_en), .cpu_ld(cpu_ld), .cpu_d(cpu_d),
   .cpu_q(cpu_q), .pin_out(pin_out)
);

// File: tb/pld_out_cell_bench.sv
module pld_out_cell_bench;
   localparam int NN = 4;
   localparam int NB = 6;
   localparam int NC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NN-1:0] pt_nat = '0, cfg_rgrp = '0;
   logic [NB-1:0] pt_brw = '0, cfg_brw_en = '0;
   logic cfg_inv = 0, cfg_clk_pt = 0, cfg_out_reg = 0, clk_in = 0, pt_clk = 0;
   logic [1:0] cfg_mode = 2'd0;
   logic pt_pre = 0, cfg_pre_en = 0, cpu_ld = 0, cpu_d = 0;
   logic [NC-1:0] pt_clr = '0, cfg_clr_en = '0;
   logic cpu_q, pin_out, fb_out;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic q_m = 0, pe_m = 0, pp_m = 0;
   bit last_ld = 0;

   always #2 clk = ~clk;

   pld_out_cell #(.N_NAT(NN), .N_BRW(NB), .N_CLR(NC)) u_pld_out_cell (.*);

   function automatic logic f_sum();
      return ((|(pt_nat & ~cfg_rgrp)) | (|(pt_brw & cfg_brw_en))) ^ cfg_inv;
   endfunction

   function automatic logic f_rst();
      return |(pt_nat & cfg_rgrp);
   endfunction

   function automatic logic f_next(input logic q, input logic s, input logic r);
      case (cfg_mode)
         2'd0: return s;
         2'd1: return q ^ s;
         2'd2: return (s & r) ? ~q : (s ? 1'b1 : (r ? 1'b0 : q));
         default: return (s & ~r) ? 1'b1 : ((r & ~s) ? 1'b0 : q);
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: inputs already driven at a falling edge
   task automatic step();
      logic clr, pre, qe, s, ev, nq;
      string tq, tp;
      #1;
      clr = |(pt_clr & cfg_clr_en);
      pre = pt_pre & cfg_pre_en;
      qe  = clr ? 1'b0 : (pre ? 1'b1 : q_m);
      s   = f_sum();
      tq  = clr ? "R9" : (pre ? "R10" : (last_ld ? "R11" :
            (cfg_mode == 0 ? "R4" : cfg_mode == 1 ? "R5" : cfg_mode == 2 ? "R6" : "R7")));
      tp  = cfg_out_reg ? tq : (cfg_inv ? "R2" : "R1");
      check(cpu_q === qe, tq, cpu_q, qe);
      check(pin_out === (cfg_out_reg ? qe : s), tp, pin_out, cfg_out_reg ? qe : s);
      check(fb_out === pin_out, "R3", fb_out, pin_out);
      ev = cfg_clk_pt ? (pt_clk & ~pp_m) : (clk_in & ~pe_m);
      nq = clr ? 1'b0 : pre ? 1'b1 : cpu_ld ? cpu_d : ev ? f_next(q_m, s, f_rst()) : q_m;
      last_ld = cpu_ld & ~clr & ~pre;
      @(posedge clk);
      q_m = nq; pe_m = clk_in; pp_m = pt_clk;
      @(negedge clk);
   endtask

   task automatic quiet();
      pt_clr = '0; pt_pre = 0; cpu_ld = 0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1 check(cpu_q === 1'b0, "R12", cpu_q, 1'b0);
      cfg_out_reg = 1;
      #1 check(pin_out === 1'b0, "R12", pin_out, 1'b0);
      @(negedge clk); rst_n = 1; cfg_out_reg = 0;

      // R1: disabled borrowed terms are ignored
      pt_brw = '1; cfg_brw_en = '0; pt_nat = '0;
      step();
      cfg_brw_en = 6'b000100; step();
      cfg_inv = 1; step();                                   // R2
      cfg_brw_en = '0; cfg_inv = 0;

      // R8: held-high source and unselected source never update
      cfg_out_reg = 1; cfg_mode = 2'd0; cfg_clk_pt = 0;
      pt_nat = 4'b0001; clk_in = 1; step();                 // event loads 1
      pt_nat = 4'b0000; step(); step();                     // held high
      check(cpu_q === 1'b1, "R8", cpu_q, 1'b1);
      pt_clk = 1; step(); pt_clk = 0; step();               // unselected
      check(cpu_q === 1'b1, "R8", cpu_q, 1'b1);
      clk_in = 0; step();

      // R7: SR with both inputs high holds
      cfg_mode = 2'd3; cfg_rgrp = 4'b0010; pt_nat = 4'b0011;
      clk_in = 1; step(); clk_in = 0; step();
      check(cpu_q === 1'b1, "R7", cpu_q, 1'b1);

      // R9: clear wins over preset
      pt_clr = 2'b10; cfg_clr_en = 2'b10; pt_pre = 1; cfg_pre_en = 1; step();
      quiet(); step();
      check(cpu_q === 1'b0, "R9", cpu_q, 1'b0);
      pt_pre = 1; step(); quiet(); step();                  // R10
      check(cpu_q === 1'b1, "R10", cpu_q, 1'b1);

      // R11: load overrides a same-cycle event
      cfg_mode = 2'd0; pt_nat = 4'b0001; cfg_rgrp = '0;
      cpu_ld = 1; cpu_d = 0; clk_in = 1; step();
      quiet(); clk_in = 0; step();
      check(cpu_q === 1'b0, "R11", cpu_q, 1'b0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         if (i % 40 == 0) begin
            cfg_mode    = 2'($urandom);
            cfg_inv     = 1'($urandom);
            cfg_out_reg = 1'($urandom);
            cfg_clk_pt  = 1'($urandom);
            cfg_rgrp    = NN'($urandom);
            cfg_brw_en  = NB'($urandom);
            cfg_clr_en  = NC'($urandom);
            cfg_pre_en  = 1'($urandom);
         end
         pt_nat = NN'($urandom) & NN'($urandom);
         pt_brw = ($urandom % 3 == 0) ? NB'($urandom) : '0;
         clk_in = 1'($urandom);
         pt_clk = 1'($urandom);
         pt_clr = ($urandom % 16 == 0) ? NC'($urandom) : '0;
         pt_pre = ($urandom % 12 == 0);
         cpu_ld = ($urandom % 8 == 0);
         cpu_d  = 1'($urandom);
         step();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule